// File: doc/BRIEF.md
# GPIO Input Change Interrupt Detector

This block watches a bank of general-purpose input lines and turns changes on them into latched interrupt events. Each line is brought into the clock domain by a two-flop synchronizer. A line that has not been switched into the extended sensing mode reports any transition. A line in the extended mode reports either an edge or a level, and the polarity is selectable: rising edge or high level, or falling edge or low level.

Detected events collect in an event status word. Reading that word returns its contents and clears them. An event that arrives in the same cycle as the read is kept for the next read. An enable mask selects which status bits drive the single registered interrupt output. Every configuration word has its own write-ones-to-set and write-ones-to-clear addresses and can be read back at a third address.

Software reaches the block through a small register bus. A write is accepted in the cycle in which `bus_sel` and `bus_wr` are both high. A read is taken in the cycle in which `bus_sel` is high and `bus_wr` is low. Read data appears on `bus_rdata` after the next clock edge and holds until the next read.

Top module: `gci_top`

Word addresses: 0 enable set, 1 enable clear, 2 enable readback, 3 extended-mode set, 4 extended-mode clear, 5 extended-mode readback, 6 level-select (set level), 7 edge-select (clear level), 8 level readback, 9 high-select (set polarity), 10 low-select (clear polarity), 11 polarity readback, 12 event status (clear on read). Bit i of every word belongs to line i.

## Requirements
- R1: After a synchronous reset the enable, extended-mode, level and polarity words all read 0, and so does the event status. A 0 level bit means edge sensing and a 0 polarity bit means falling/low. The interrupt output is 0.
- R2: Writing to address 0 sets the enable bits where the data has ones. Writing to address 1 clears them where the data has ones. Zero data bits leave bits unchanged. Address 2 returns the enable word.
- R3: Addresses 3 and 4 set and clear the extended-mode bits in the same write-ones manner, and address 5 returns them.
- R4: Address 6 sets level bits (level sensing) and address 7 clears them (edge sensing), with ones selecting lines. Address 8 returns the level word.
- R5: Address 9 sets polarity bits (rising/high) and address 10 clears them (falling/low), with ones selecting lines. Address 11 returns the polarity word.
- R6: A line whose extended-mode bit is 0 sets its status bit on both a rising and a falling input transition.
- R7: A line with extended mode on and level bit 0 sets its status bit only on a rising transition when its polarity bit is 1, and only on a falling transition when its polarity bit is 0.
- R8: A line with extended mode on and level bit 1 sets its status bit on every cycle while its synchronized input equals its polarity bit, so a read does not leave the bit clear while the level stays active.
- R9: A read of address 12 returns the status word and clears every bit that has no new event in that cycle.
- R10: An event detected in the same cycle as a status read is not returned by that read, but it is held and returned by the following read.
- R11: The interrupt output is high exactly when some status bit is set together with its enable bit, one cycle later. A disabled line still latches status but does not raise the interrupt.
- R12: An input change set up before clock edge k raises its status bit at edge k+2 and, when enabled, the interrupt output at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | W (32) | Write data, one bit per line |
| bus_rdata | output | W (32) | Registered read data |
| pin_in | input | W (32) | Asynchronous input lines |
| irq | output | 1 | Registered combined interrupt |

## Verification
A wrong mode bit or a stale previous-sample flop shows up at the ports as a wrong event status word. The word is wrong at the first read after the input change, which is two cycles after the change is sampled. A status bit that the read fails to clear, or an event that the read swallows, shows in the next status read. A mask fault shows on the interrupt output one cycle after the status bit sets. The sweep tries many mixes of extended mode, level and polarity against many old and new input words, so a per-line decode fault reaches a compared status bit.

// File: rtl/gci_pkg.sv
package gci_pkg;
  localparam int REG_AW = 4;
  localparam int NCFG = 4;

  typedef enum logic [REG_AW-1:0] {
    A_EN_SET   = 4'd0,
    A_EN_CLR   = 4'd1,
    A_EN_STAT  = 4'd2,
    A_XM_SET   = 4'd3,
    A_XM_CLR   = 4'd4,
    A_XM_STAT  = 4'd5,
    A_LVL_SET  = 4'd6,
    A_EDG_SET  = 4'd7,
    A_LVL_STAT = 4'd8,
    A_HI_SET   = 4'd9,
    A_LO_SET   = 4'd10,
    A_POL_STAT = 4'd11,
    A_EVT_STAT = 4'd12
  } reg_addr_e;

  // configuration word index: 0 enable, 1 extended mode, 2 level, 3 polarity
  function automatic logic [REG_AW-1:0] set_addr(input int k);
    case (k)
      0:       set_addr = A_EN_SET;
      1:       set_addr = A_XM_SET;
      2:       set_addr = A_LVL_SET;
      default: set_addr = A_HI_SET;
    endcase
  endfunction

  function automatic logic [REG_AW-1:0] clr_addr(input int k);
    case (k)
      0:       clr_addr = A_EN_CLR;
      1:       clr_addr = A_XM_CLR;
      2:       clr_addr = A_EDG_SET;
      default: clr_addr = A_LO_SET;
    endcase
  endfunction
endpackage

// File: rtl/gci_sync.sv
module gci_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      cur  <= '0;
      prev <= '0;
    end else begin
      meta <= din;
      cur  <= meta;
      prev <= cur;
    end
  end
endmodule

// File: rtl/gci_setclr.sv
module gci_setclr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (set_en) begin
      q <= q | wdata;
    end else if (clr_en) begin
      q <= q & ~wdata;
    end
  end
endmodule

// File: rtl/gci_detect.sv
module gci_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] xmode,
  input  logic [W-1:0] level,
  input  logic [W-1:0] pol,
  output logic [W-1:0] evt
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic rise, fall, active;
    always_comb begin
      rise   = cur[i] & ~prev[i];
      fall   = ~cur[i] & prev[i];
      active = ~(cur[i] ^ pol[i]);
      if (!xmode[i])
        evt[i] = rise | fall;
      else if (level[i])
        evt[i] = active;
      else
        evt[i] = pol[i] ? rise : fall;
    end
  end
endmodule

// File: rtl/gci_status.sv
module gci_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         rd_clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] status,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= evt | (rd_clr ? '0 : status);
      irq    <= |(status & mask);
    end
  end
endmodule

// File: rtl/gci_top.sv
module gci_top
  import gci_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic              irq
);
  logic          wr_acc, rd_acc, rd_evt;
  logic [W-1:0]  cfg_q [NCFG];
  logic [W-1:0]  en_q, xmode_q, level_q, pol_q;
  logic [W-1:0]  s_cur, s_prev, evt, status;

  assign wr_acc = bus_sel & bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;
  assign rd_evt = rd_acc & (bus_addr == ADDR_W'(A_EVT_STAT));

  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    logic set_hit, clr_hit;
    assign set_hit = wr_acc & (bus_addr == ADDR_W'(set_addr(k)));
    assign clr_hit = wr_acc & (bus_addr == ADDR_W'(clr_addr(k)));
    gci_setclr #(.W(W)) u_reg (
      .clk(clk), .rst(rst), .set_en(set_hit), .clr_en(clr_hit),
      .wdata(bus_wdata), .q(cfg_q[k])
    );
  end

  assign en_q    = cfg_q[0];
  assign xmode_q = cfg_q[1];
  assign level_q = cfg_q[2];
  assign pol_q   = cfg_q[3];

  gci_sync #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .cur(s_cur), .prev(s_prev)
  );

  gci_detect #(.W(W)) u_det (
    .cur(s_cur), .prev(s_prev), .xmode(xmode_q), .level(level_q),
    .pol(pol_q), .evt(evt)
  );

  gci_status #(.W(W)) u_stat (
    .clk(clk), .rst(rst), .evt(evt), .rd_clr(rd_evt), .mask(en_q),
    .status(status), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_acc) begin
      case (bus_addr)
        ADDR_W'(A_EN_STAT):  bus_rdata <= en_q;
        ADDR_W'(A_XM_STAT):  bus_rdata <= xmode_q;
        ADDR_W'(A_LVL_STAT): bus_rdata <= level_q;
        ADDR_W'(A_POL_STAT): bus_rdata <= pol_q;
        ADDR_W'(A_EVT_STAT): bus_rdata <= status;
        default:             bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gci_checker.sv
module gci_checker #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  en_q,
  input logic [W-1:0]  xmode_q,
  input logic [W-1:0]  level_q,
  input logic [W-1:0]  pol_q,
  input logic [W-1:0]  s_cur,
  input logic [W-1:0]  s_prev,
  input logic [W-1:0]  evt,
  input logic [W-1:0]  status,
  input logic          rd_evt,
  input logic          irq
);
  logic [W-1:0] anyedge_lines, level_act;
  assign anyedge_lines = ~xmode_q & (s_cur ^ s_prev);
  assign level_act     = xmode_q & level_q & ~(s_cur ^ pol_q);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && status == '0 && en_q == '0)); // R1

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == AW'(0)) |=>
      ((en_q & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_ANY_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
    (anyedge_lines != '0) |=>
      ((status & $past(anyedge_lines)) == $past(anyedge_lines))); // R6

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (level_act != '0) |=> ((status & $past(level_act)) == $past(level_act))); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && evt == '0) |=> (status == '0)); // R9

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt))); // R10

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) == '0) |-> !irq); // R11
endmodule

bind gci_top gci_checker #(.W(W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .en_q(en_q),
  .xmode_q(xmode_q), .level_q(level_q), .pol_q(pol_q), .s_cur(s_cur),
  .s_prev(s_prev), .evt(evt), .status(status), .rd_evt(rd_evt), .irq(irq)
);

// File: tb/tb_gci_top.sv
`timescale 1ns/1ps
module tb_gci_top;
  localparam int W = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  pin_in = '0;
  logic          irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gci_top #(.W(W), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [W-1:0] x, input logic [W-1:0] l, input logic [W-1:0] p);
    wr(3, x); wr(4, ~x);
    wr(6, l); wr(7, ~l);
    wr(9, p); wr(10, ~p);
  endtask

  function automatic logic [W-1:0] expect_evt(input logic [W-1:0] x, input logic [W-1:0] l,
                                              input logic [W-1:0] p, input logic [W-1:0] v,
                                              input logic [W-1:0] w);
    logic [W-1:0] rise, fall, act_v, act_w;
    rise  = ~v & w;
    fall  = v & ~w;
    act_v = ~(v ^ p);
    act_w = ~(w ^ p);
    return (~x & (rise | fall)) |
           (x & ~l & ((p & rise) | (~p & fall))) |
           (x & l & (act_v | act_w));
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] d, x, l, p, v, w;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2, d);  check("R1 enable", d, '0);
    rd(5, d);  check("R1 xmode", d, '0);
    rd(8, d);  check("R1 level", d, '0);
    rd(11, d); check("R1 polarity", d, '0);
    rd(12, d); check("R1 status", d, '0);
    check("R1 irq", W'(irq), '0);

    // R2 enable set/clear
    wr(0, 32'hA5A5_0001); rd(2, d); check("R2 set", d, 32'hA5A5_0001);
    wr(0, 32'h0);         rd(2, d); check("R2 zero set", d, 32'hA5A5_0001);
    wr(1, 32'h0000_0001); rd(2, d); check("R2 clear", d, 32'hA5A5_0000);
    wr(1, 32'hFFFF_FFFF); rd(2, d); check("R2 clear all", d, '0);

    // R3 R4 R5 set/clear readback
    wr(3, 32'h0F0F_00FF); wr(4, 32'h0000_000F); rd(5, d); check("R3", d, 32'h0F0F_00F0);
    wr(6, 32'h3800_0038); wr(7, 32'h3800_0000); rd(8, d); check("R4", d, 32'h0000_0038);
    wr(9, 32'h0000_00B5); wr(10, 32'h0000_0004); rd(11, d); check("R5", d, 32'h0000_00B1);

    // R6 R7 R8 sweep over mixed configurations and input words
    for (int t = 0; t < 48; t++) begin
      if (t == 0) begin
        x = 32'h0000_00FF; l = 32'h0000_0038; p = 32'h0000_00B5;
      end else begin
        x = W'(t * 32'h27D4_EB2F);
        l = W'(t * 32'h1656_67B1) ^ (x >> 3);
        p = W'(t * 32'h9E37_79B9) ^ 32'h5555_AAAA;
      end
      v = W'((t + 3) * 32'h85EB_CA6B);
      w = v ^ W'((t + 7) * 32'hC2B2_AE35);
      set_cfg(x, l, p);
      pin_in = v;
      idle(5);
      rd(12, d);
      pin_in = w;
      idle(5);
      rd(12, d);
      check($sformatf("R6 R7 R8 sweep %0d", t), d, expect_evt(x, l, p, v, w));
    end

    // quiet down: all lines any-edge, inputs low, status clear
    set_cfg('0, '0, '0);
    pin_in = '0;
    idle(5);
    rd(12, d); rd(12, d);
    check("R9 quiet", d, '0);

    // R9 clear on read
    pin_in = 32'h8000_0010;
    idle(5);
    rd(12, d); check("R9 first read", d, 32'h8000_0010);
    rd(12, d); check("R9 cleared", d, '0);

    // R8 level held through reads, then released
    set_cfg(32'h0000_0008, 32'h0000_0008, 32'h0000_0008);
    pin_in = 32'h8000_0018;
    idle(5);
    rd(12, d); rd(12, d); check("R8 held after read", d, 32'h0000_0008);
    pin_in = 32'h8000_0010;
    idle(5);
    rd(12, d); rd(12, d); check("R8 released", d, '0);
    set_cfg('0, '0, '0);
    pin_in = '0;
    idle(5);
    rd(12, d); rd(12, d);

    // R10 event in the read cycle is kept
    @(negedge clk); pin_in = 32'h0000_0001;     // sampled at edge k
    @(negedge clk);                             // after k
    @(negedge clk);                             // after k+1
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(12);
    @(negedge clk);                             // after k+2
    d = bus_rdata; bus_sel = 1'b0;
    check("R10 not in same read", d, '0);
    rd(12, d); check("R10 kept", d, 32'h0000_0001);

    // R12 and R11 timing with enable on line 5
    wr(0, 32'h0000_0020);
    rd(12, d); check("R12 clean", d, '0);
    @(negedge clk); pin_in = 32'h0000_0021;     // sampled at edge k
    @(negedge clk); check("R12 irq k", W'(irq), '0);
    @(negedge clk); check("R12 irq k+1", W'(irq), '0);
    @(negedge clk); check("R12 irq k+2", W'(irq), '0);
    @(negedge clk); check("R12 irq k+3", W'(irq), 1);
    rd(12, d); check("R11 status", d, 32'h0000_0020);
    @(negedge clk); check("R11 irq drops", W'(irq), '0);

    // R11 disabled line latches but stays silent
    pin_in = 32'h0000_0061;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R11 masked irq", W'(irq), '0);
    end
    rd(12, d); check("R11 masked status", d, 32'h0000_0040);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule